// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers events from two sources into an 8-bit pending register and drives an active-low interrupt line whenever a pending event is also enabled in an 8-bit mask. One source is a periodic one-second tick pulse. The other is a peripheral-bus reply source that posts a reply packet of up to DEPTH bytes, either as an answer to an explicit request or as an unsolicited auto-poll result.

Software-side control arrives as byte packets on a simple beat interface: the first beat carries a command code, the following beats carry argument bytes, and the command executes on the beat marked last. Two commands are served. Set-mask replaces the enable mask. Acknowledge returns a response stream on the response port. If a bus reply is waiting, the response holds the bus-related status bits and then the stored reply bytes. Otherwise it holds the whole pending register, and that register is cleared.

Top module: `evirq_top`

## Requirements
- R1: `irq_n` is low exactly when (pending AND mask) is nonzero, and it changes on the same clock edge that changes the pending register or the mask.
- R2: After reset the pending register is zero, the mask is 0x11 (bus-reply event at bit 0 and tick event at bit 4 enabled), `irq_n` is high and `rsp_valid` is low.
- R3: A packet with code 0x2D and exactly one argument byte replaces the mask with that byte. A 0x2D packet with zero, two or more arguments leaves the mask unchanged.
- R4: A packet with code 0x4B and no argument bytes is an acknowledge. A 0x4B packet that carries any argument byte produces no response and clears nothing.
- R5: When an acknowledge executes with bit 0 pending, the response is a status byte equal to pending AND 0x05 (bit 0 bus reply, bit 2 auto-poll), followed by the stored reply bytes, byte 0 first. Only bits 0 and 2 are cleared, and the stored reply is discarded.
- R6: When an acknowledge executes with bit 0 not pending, the response is one byte holding the whole pending register, and the whole register is cleared.
- R7: An auto-poll reply (`rpl_auto`=1) is accepted only while bit 0 is not pending. Acceptance stores it and sets bits 0 and 2. A rejected auto-poll reply changes neither the pending bits nor the stored reply.
- R8: An explicit reply (`rpl_auto`=0) is always accepted. It replaces the stored reply and sets bit 0 only.
- R9: A `tick_evt` pulse sets pending bit 4.
- R10: An event that arrives on the same edge where an acknowledge clears the pending bits remains pending.
- R11: The first response byte appears with `rsp_valid` on the edge that executes the acknowledge. The remaining bytes follow on consecutive cycles, and `rsp_last` marks the final byte.
- R12: An acknowledge that completes while a response is still streaming is ignored.
- R13: A packet whose command code is neither 0x2D nor 0x4B has no effect and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Command beat present |
| pkt_first | input | 1 | Beat carries the command code |
| pkt_last | input | 1 | Final beat of the packet |
| pkt_data | input | 8 | Beat byte |
| tick_evt | input | 1 | One-second tick pulse |
| rpl_post | input | 1 | Peripheral reply posted this cycle |
| rpl_auto | input | 1 | Posted reply is an auto-poll result |
| rpl_len | input | 4 | Reply byte count (clamped to DEPTH) |
| rpl_bytes | input | 64 | Reply bytes, byte i at bits [8i+7:8i] |
| irq_n | output | 1 | Active-low interrupt |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final response byte |

## Verification
A corrupted pending or mask register shows up on `irq_n` in the next cycle. It also shows up in the status byte of the next acknowledge, because that byte exposes the pending register directly. A wrong stored reply or a wrong stream counter appears as wrong bytes, a gap in `rsp_valid`, or a misplaced `rsp_last` within DEPTH+1 cycles of the acknowledge. The bench covers coincident events and clears, rejected auto-poll replies, and an acknowledge that arrives in the middle of a stream. Faults that only appear under those conditions would otherwise hide.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  localparam int EW       = 8;
  localparam int BUS_BIT  = 0;
  localparam int AUTO_BIT = 2;
  localparam int TICK_BIT = 4;

  localparam logic [EW-1:0] BUS_M  = EW'(1) << BUS_BIT;
  localparam logic [EW-1:0] AUTO_M = EW'(1) << AUTO_BIT;
  localparam logic [EW-1:0] TICK_M = EW'(1) << TICK_BIT;
  localparam logic [EW-1:0] BA_M   = BUS_M | AUTO_M;
  localparam logic [EW-1:0] RST_MASK = BUS_M | TICK_M;

  localparam logic [7:0] CODE_ACK  = 8'h4B;
  localparam logic [7:0] CODE_MASK = 8'h2D;
endpackage

// File: rtl/evirq_pkt_rx.sv
module evirq_pkt_rx
  import evirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pkt_valid,
  input  logic       pkt_first,
  input  logic       pkt_last,
  input  logic [7:0] pkt_data,
  output logic       ack_go,
  output logic       mask_go,
  output logic [7:0] mask_val
);
  logic [7:0] code_q, arg0_q, eff_code;
  logic [1:0] nargs_q, eff_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      arg0_q  <= '0;
      nargs_q <= '0;
    end else if (pkt_valid) begin
      if (pkt_first) begin
        code_q  <= pkt_data;
        nargs_q <= '0;
      end else begin
        if (nargs_q == 2'd0) arg0_q <= pkt_data;
        if (nargs_q != 2'd2) nargs_q <= nargs_q + 2'd1;
      end
    end
  end

  // counts the beat under way so a command executes on its last beat
  always_comb begin
    eff_code = pkt_first ? pkt_data : code_q;
    if (pkt_first)             eff_n = 2'd0;
    else if (nargs_q == 2'd2)  eff_n = 2'd2;
    else                       eff_n = nargs_q + 2'd1;
    mask_val = (!pkt_first && nargs_q == 2'd0) ? pkt_data : arg0_q;
  end

  assign ack_go  = pkt_valid && pkt_last && (eff_code == CODE_ACK)  && (eff_n == 2'd0);
  assign mask_go = pkt_valid && pkt_last && (eff_code == CODE_MASK) && (eff_n == 2'd1);

  // R4
  ack_len_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_go |-> (pkt_first && pkt_last)));
endmodule

// File: rtl/evirq_core.sv
module evirq_core
  import evirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rpl_post,
  input  logic          rpl_auto,
  input  logic          ack_fire,
  input  logic          mask_wr,
  input  logic [EW-1:0] mask_val,
  output logic [EW-1:0] pend,
  output logic [EW-1:0] status,
  output logic          ack_bus,
  output logic          rpl_acc,
  output logic          irq_n
);
  logic [EW-1:0] pend_q, mask_q, pend_nxt, mask_nxt, clr_b, set_b;
  logic          irq_n_q;

  always_comb begin
    rpl_acc = rpl_post && (!rpl_auto || !pend_q[BUS_BIT]);
    set_b   = (tick ? TICK_M : '0) |
              (rpl_acc ? (BUS_M | (rpl_auto ? AUTO_M : '0)) : '0);
    clr_b   = ack_fire ? (pend_q[BUS_BIT] ? BA_M : '1) : '0;
    pend_nxt = (pend_q & ~clr_b) | set_b;
    mask_nxt = mask_wr ? mask_val : mask_q;
    status   = pend_q[BUS_BIT] ? (pend_q & BA_M) : pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      mask_q  <= RST_MASK;
      irq_n_q <= 1'b1;
    end else begin
      pend_q  <= pend_nxt;
      mask_q  <= mask_nxt;
      irq_n_q <= ~|(pend_nxt & mask_nxt);
    end
  end

  assign pend    = pend_q;
  assign ack_bus = pend_q[BUS_BIT];
  assign irq_n   = irq_n_q;

  // R1
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_n_q == ~|(pend_q & mask_q)));
  // R2
  reset_state_chk: assert property (@(posedge clk)
    (rst |=> (pend_q == '0 && mask_q == RST_MASK && irq_n_q)));
  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_wr |=> mask_q == $past(mask_val)));
  // R5
  bus_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((ack_fire && pend_q[BUS_BIT] && !tick && !rpl_post) |=>
      pend_q == ($past(pend_q) & ~BA_M)));
  // R6
  all_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((ack_fire && !pend_q[BUS_BIT] && !tick && !rpl_post) |=> pend_q == '0));
  // R7
  auto_reject_chk: assert property (@(posedge clk) disable iff (rst)
    ((rpl_post && rpl_auto && pend_q[BUS_BIT] && !ack_fire && !tick) |=>
      $stable(pend_q)));
  // R10
  tick_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (tick |=> pend_q[TICK_BIT]));
endmodule

// File: rtl/evirq_rsp_tx.sv
module evirq_rsp_tx
  import evirq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rpl_acc,
  input  logic [LEN_W-1:0]   rpl_len,
  input  logic [DEPTH*8-1:0] rpl_bytes,
  input  logic               ack_fire,
  input  logic               ack_bus,
  input  logic [EW-1:0]      status,
  output logic               busy,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               rsp_last
);
  logic [7:0]       buf_q [DEPTH];
  logic [7:0]       sh_q  [DEPTH];
  logic [LEN_W-1:0] len_q, rem_q, len_in, n_out;

  assign len_in = (rpl_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : rpl_len;
  assign n_out  = ack_bus ? len_q : '0;
  assign busy   = (rem_q != '0);

  // reply store: plain byte array without reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (rpl_acc) buf_q[g] <= rpl_bytes[g*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else if (rpl_acc) len_q <= len_in;
    else if (ack_fire && ack_bus) len_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (ack_fire) begin
      for (int i = 0; i < DEPTH; i++) sh_q[i] <= buf_q[i];
    end else if (busy) begin
      for (int i = 0; i < DEPTH - 1; i++) sh_q[i] <= sh_q[i+1];
      sh_q[DEPTH-1] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
    end else if (ack_fire) begin
      rem_q     <= n_out;
      rsp_valid <= 1'b1;
      rsp_data  <= status;
      rsp_last  <= (n_out == '0);
    end else if (busy) begin
      rem_q     <= rem_q - LEN_W'(1);
      rsp_valid <= 1'b1;
      rsp_data  <= sh_q[0];
      rsp_last  <= (rem_q == LEN_W'(1));
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
    end
  end

  // R11
  rsp_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire |=> rsp_valid));
  // R11
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_last |-> rsp_valid));
  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rem_q <= LEN_W'(DEPTH) && len_q <= LEN_W'(DEPTH)));
endmodule

// File: rtl/evirq_top.sv
module evirq_top
  import evirq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkt_valid,
  input  logic               pkt_first,
  input  logic               pkt_last,
  input  logic [7:0]         pkt_data,
  input  logic               tick_evt,
  input  logic               rpl_post,
  input  logic               rpl_auto,
  input  logic [LEN_W-1:0]   rpl_len,
  input  logic [DEPTH*8-1:0] rpl_bytes,
  output logic               irq_n,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               rsp_last
);
  logic          ack_go, mask_go, ack_fire, ack_bus, rpl_acc, busy;
  logic [7:0]    mask_val;
  logic [EW-1:0] pend, status;

  evirq_pkt_rx u_rx (
    .clk(clk), .rst(rst),
    .pkt_valid(pkt_valid), .pkt_first(pkt_first), .pkt_last(pkt_last),
    .pkt_data(pkt_data),
    .ack_go(ack_go), .mask_go(mask_go), .mask_val(mask_val)
  );

  assign ack_fire = ack_go && !busy;

  evirq_core u_core (
    .clk(clk), .rst(rst),
    .tick(tick_evt), .rpl_post(rpl_post), .rpl_auto(rpl_auto),
    .ack_fire(ack_fire), .mask_wr(mask_go), .mask_val(mask_val),
    .pend(pend), .status(status), .ack_bus(ack_bus), .rpl_acc(rpl_acc),
    .irq_n(irq_n)
  );

  evirq_rsp_tx #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst),
    .rpl_acc(rpl_acc), .rpl_len(rpl_len), .rpl_bytes(rpl_bytes),
    .ack_fire(ack_fire), .ack_bus(ack_bus), .status(status),
    .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    ((busy && ack_go && !tick_evt && !rpl_post) |=> $stable(pend)));
endmodule

// File: tb/sim_evirq_top.sv
module sim_evirq_top;
  localparam int DEPTH = 8;
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam logic [7:0] ACK = 8'h4B;
  localparam logic [7:0] MSK = 8'h2D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pv = 0, pf = 0, pl = 0;
  logic [7:0] pd = '0;
  logic tk = 0, rp = 0, ra = 0;
  logic [LEN_W-1:0] rlen = '0;
  logic [DEPTH*8-1:0] rbytes = '0;
  logic irq_n, rsp_valid, rsp_last;
  logic [7:0] rsp_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] got [16];

  always #5 clk = ~clk;

  evirq_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .pkt_valid(pv), .pkt_first(pf), .pkt_last(pl), .pkt_data(pd),
    .tick_evt(tk), .rpl_post(rp), .rpl_auto(ra), .rpl_len(rlen),
    .rpl_bytes(rbytes),
    .irq_n(irq_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last)
  );

  // mask value, tick applied, expected irq_n, expected acknowledge byte
  localparam logic [17:0] VEC [6] = '{
    {8'h10, 1'b1, 1'b0, 8'h10},
    {8'h00, 1'b1, 1'b1, 8'h10},
    {8'hEF, 1'b1, 1'b1, 8'h10},
    {8'hFF, 1'b0, 1'b1, 8'h00},
    {8'h10, 1'b0, 1'b1, 8'h00},
    {8'h90, 1'b1, 1'b0, 8'h10}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d, input bit f, input bit l);
    @(negedge clk);
    pv = 1; pf = f; pl = l; pd = d;
  endtask

  task automatic send(input logic [7:0] code, input int n,
                      input logic [7:0] a0, input logic [7:0] a1);
    if (n == 0) beat(code, 1, 1);
    else begin
      beat(code, 1, 0);
      if (n == 1) beat(a0, 0, 1);
      else begin
        beat(a0, 0, 0);
        beat(a1, 0, 1);
      end
    end
    @(negedge clk);
    pv = 0; pf = 0; pl = 0;
  endtask

  task automatic tick;
    @(negedge clk); tk = 1;
    @(negedge clk); tk = 0;
  endtask

  task automatic post(input bit auto_f, input int len,
                      input logic [DEPTH*8-1:0] b);
    @(negedge clk); rp = 1; ra = auto_f; rlen = LEN_W'(len); rbytes = b;
    @(negedge clk); rp = 0; ra = 0;
  endtask

  task automatic collect(output int cnt, output bit gap, output int dly);
    cnt = 0; gap = 0; dly = 0;
    while (!rsp_valid && dly < 4) begin
      @(negedge clk);
      dly++;
    end
    if (rsp_valid) begin
      for (int k = 0; k < 16; k++) begin
        got[cnt] = rsp_data;
        cnt++;
        if (rsp_last) break;
        @(negedge clk);
        if (!rsp_valid) begin
          gap = 1;
          break;
        end
      end
    end
  endtask

  task automatic check_stream(input string req, input int n,
                              input logic [71:0] ev, input int cnt,
                              input bit gap, input int dly);
    chk(dly == 0, req, dly, 0);
    chk(!gap, req, gap, 0);
    chk(cnt == n, req, cnt, n);
    for (int i = 0; i < n && i < cnt; i++)
      chk(got[i] == ev[i*8 +: 8], req, got[i], ev[i*8 +: 8]);
  endtask

  task automatic ack_expect(input string req, input int n, input logic [71:0] ev);
    int cnt, dly;
    bit gap;
    send(ACK, 0, 0, 0);
    collect(cnt, gap, dly);
    check_stream(req, n, ev, cnt, gap, dly);
  endtask

  task automatic no_rsp(input string req);
    for (int i = 0; i < 3; i++) begin
      chk(!rsp_valid, req, rsp_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt, dly;
    bit gap;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state at the ports
    chk(irq_n == 1'b1, "R2 irq_n", irq_n, 1);
    chk(rsp_valid == 1'b0, "R2 rsp_valid", rsp_valid, 0);
    // R2 / R9: tick enabled by reset mask
    tick();
    chk(irq_n == 1'b0, "R9 tick raises irq", irq_n, 0);
    ack_expect("R6 all-pending read", 1, 72'h10);
    @(negedge clk);
    chk(irq_n == 1'b1, "R6 cleared", irq_n, 1);
    // R2 / R5: bus bit enabled by reset, empty explicit reply
    post(0, 0, '0);
    chk(irq_n == 1'b0, "R2 bus enabled", irq_n, 0);
    ack_expect("R5 empty reply", 1, 72'h01);
    @(negedge clk);
    chk(irq_n == 1'b1, "R5 cleared", irq_n, 1);

    // R1 R3 R6 table
    for (int v = 0; v < 6; v++) begin
      send(MSK, 1, VEC[v][17:10], 0);
      if (VEC[v][9]) tick();
      chk(irq_n == VEC[v][8], "R1 masked irq", irq_n, VEC[v][8]);
      ack_expect("R6 table ack", 1, {64'h0, VEC[v][7:0]});
      @(negedge clk);
      chk(irq_n == 1'b1, "R1 irq after clear", irq_n, 1);
    end

    // R3 bad lengths ignored
    send(MSK, 1, 8'h10, 0);
    send(MSK, 2, 8'h00, 8'h00);
    send(MSK, 0, 0, 0);
    tick();
    chk(irq_n == 1'b0, "R3 mask kept", irq_n, 0);
    ack_expect("R3 ack", 1, 72'h10);

    // R4 acknowledge with an argument
    tick();
    send(ACK, 1, 8'h00, 0);
    no_rsp("R4 no response");
    chk(irq_n == 1'b0, "R4 nothing cleared", irq_n, 0);
    ack_expect("R4 proper ack", 1, 72'h10);

    // R13 unknown code
    tick();
    send(8'h00, 0, 0, 0);
    no_rsp("R13 no response");
    chk(irq_n == 1'b0, "R13 pending kept", irq_n, 0);
    ack_expect("R13 ack", 1, 72'h10);

    // R5 R8 explicit reply with tick pending
    send(MSK, 1, 8'h11, 0);
    post(0, 3, 64'hC3B2A1);
    tick();
    chk(irq_n == 1'b0, "R8 reply irq", irq_n, 0);
    ack_expect("R5 reply stream", 4, 72'hC3B2A101);
    @(negedge clk);
    chk(irq_n == 1'b0, "R5 tick survives", irq_n, 0);
    ack_expect("R6 tick after bus", 1, 72'h10);
    @(negedge clk);
    chk(irq_n == 1'b1, "R6 empty", irq_n, 1);

    // R7 auto-poll accept and reject
    post(1, 2, 64'hE5D4);
    chk(irq_n == 1'b0, "R7 auto accepted", irq_n, 0);
    post(1, 1, 64'h77);
    ack_expect("R7 rejected second auto", 3, 72'hE5D405);
    @(negedge clk);
    chk(irq_n == 1'b1, "R7 bits cleared", irq_n, 1);

    // R8 explicit overwrite while pending
    post(0, 1, 64'h99);
    post(0, 2, 64'h2211);
    ack_expect("R8 overwrite", 3, 72'h221101);

    // R10 tick coincident with clear
    tick();
    @(negedge clk);
    pv = 1; pf = 1; pl = 1; pd = ACK; tk = 1;
    @(negedge clk);
    pv = 0; pf = 0; pl = 0; tk = 0;
    collect(cnt, gap, dly);
    check_stream("R10 coincident ack", 1, 72'h10, cnt, gap, dly);
    @(negedge clk);
    chk(irq_n == 1'b0, "R10 event kept", irq_n, 0);
    ack_expect("R10 kept tick", 1, 72'h10);

    // R12 acknowledge during a full-length stream
    post(0, 8, 64'h8786858483828180);
    tick();
    send(ACK, 0, 0, 0);
    fork
      collect(cnt, gap, dly);
      begin
        repeat (2) @(negedge clk);
        pv = 1; pf = 1; pl = 1; pd = ACK;
        @(negedge clk);
        pv = 0; pf = 0; pl = 0;
      end
    join
    check_stream("R12 R11 full stream", 9, 72'h878685848382818001, cnt, gap, dly);
    @(negedge clk);
    chk(!rsp_valid, "R12 no second stream", rsp_valid, 0);
    chk(irq_n == 1'b0, "R12 tick still pending", irq_n, 0);
    ack_expect("R12 tick after ignore", 1, 72'h10);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule